// File: doc/BRIEF.md
# Banked Frame Error Status

This block records the error history of up to eight high-speed infrared frames. It keeps one status word per frame slot. A frame transmitter and a frame receiver drive it with error event strobes, and a frame index tells the block which slot those strobes belong to. Software sees all eight words through one read-only location and uses a 3-bit bank selector to pick the word that appears on the read port.

Each word holds six sticky flags: FIFO underrun, FIFO overrun, framing error, size error, frame abort and CRC error. A flag stays set until one of two things clears it. A chip reset or the error-reset command clears every slot. A valid beginning-of-frame detection clears only the slot that the current frame index points at, so the history of the other frames survives while a new frame starts.

Top module: `frame_err_bank`

## Requirements
- R1: While `rst_n` is low, and after it rises with no events applied, every bank reads 0x00.
- R2: `rd_data` shows the word of the bank that `bank_sel` selects, in the same cycle, and bits 1..0 of `rd_data` always read 0.
- R3: A cycle with `tx_starve`=1 and `tx_done`=0 sets bit 7 (FIFO underrun) of bank `cur_frame` from the next cycle on. When `tx_done`=1, `tx_starve` has no effect.
- R4: A cycle with `rx_push`=1 and `fifo_full`=1 sets bit 6 (FIFO overrun) of bank `cur_frame`. `rx_push` with `fifo_full`=0 has no effect.
- R5: `ev_framing`, `ev_size`, `ev_abort` and `ev_crc` set bits 5, 4, 3 and 2 of bank `cur_frame`. Every other bank is left unchanged.
- R6: Flags are sticky. A set flag stays set through later events and through any number of reads until a clearing condition occurs.
- R7: A one-cycle `err_clr` pulse clears all flags in all eight banks. It takes priority over any event in the same cycle.
- R8: `bof_ok` clears only bank `cur_frame`. The other banks keep their flags.
- R9: If `bof_ok` and an error event reach the same bank in the same cycle, the bank reads 0x00 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or master reset) |
| err_clr | input | 1 | Error-reset command, clears all banks |
| cur_frame | input | 3 | Index of the frame slot that events and BOF refer to |
| bof_ok | input | 1 | Valid beginning-of-frame strobe |
| tx_starve | input | 1 | Transmitter found the FIFO empty |
| tx_done | input | 1 | Transmitter has sent its last byte |
| rx_push | input | 1 | Receiver writes a byte into the FIFO |
| fifo_full | input | 1 | FIFO full flag |
| ev_framing | input | 1 | Framing error strobe |
| ev_size | input | 1 | Size error strobe |
| ev_abort | input | 1 | Frame abort strobe |
| ev_crc | input | 1 | CRC error strobe |
| bank_sel | input | 3 | Status bank selector |
| rd_data | output | 8 | Read data of the selected bank |

## Verification
Every word is reachable through the selector and reads back without delay, so a bank holding the wrong state shows at `rd_data` in the first cycle after the edge that corrupted it, provided that bank is selected. There are several ways for bank state to go wrong. A strobe can be steered to the wrong slot, or a BOF clear can reach too far. A flag can fail to stick, or the clear can lose to a simultaneous event. Each of these leaves one specific bank holding a value that differs from a model built from the requirements. The bench therefore reads back every bank it disturbed and also its unaffected neighbours.

// File: rtl/fe_stat_pkg.sv
package fe_stat_pkg;

   // Sticky error flags of one frame slot
   typedef struct packed {
      logic underrun;   // read bit 7
      logic overrun;    // read bit 6
      logic framing;    // read bit 5
      logic size;       // read bit 4
      logic abort;      // read bit 3
      logic crc;        // read bit 2
   } err_flags_t;

   localparam int unsigned FLAG_W    = $bits(err_flags_t);
   localparam int unsigned FLAG_LSB  = 2;
   localparam int unsigned BYTE_W    = 8;

   // Place the flags in a read byte; bits below FLAG_LSB read as zero
   function automatic logic [BYTE_W-1:0] flags_to_byte(input err_flags_t f);
      logic [BYTE_W-1:0] b;
      b = '0;
      b[FLAG_LSB +: FLAG_W] = f;
      return b;
   endfunction

endpackage

// File: rtl/fe_event_capture.sv
module fe_event_capture
   import fe_stat_pkg::*;
(
   input  logic       tx_starve,
   input  logic       tx_done,
   input  logic       rx_push,
   input  logic       fifo_full,
   input  logic       ev_framing,
   input  logic       ev_size,
   input  logic       ev_abort,
   input  logic       ev_crc,
   output err_flags_t set_o
);

   always_comb begin
      set_o          = '0;
      set_o.underrun = tx_starve & ~tx_done;
      set_o.overrun  = rx_push & fifo_full;
      set_o.framing  = ev_framing;
      set_o.size     = ev_size;
      set_o.abort    = ev_abort;
      set_o.crc      = ev_crc;
   end

endmodule

// File: rtl/fe_bank_word.sv
module fe_bank_word
   import fe_stat_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  err_flags_t set_i,
   output err_flags_t word_o
);

   err_flags_t word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word_q <= '0;
      else if (clr_i)
         word_q <= '0;
      else
         word_q <= word_q | set_i;
   end

   assign word_o = word_q;

   // R9
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (word_o == '0));

   // R6
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((word_o & $past(word_o)) == $past(word_o)));

   // R3
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ((word_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/fe_read_mux.sv
module fe_read_mux
   import fe_stat_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned SEL_W     = 3,
   parameter bit          READ_REG  = 1'b0
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  err_flags_t [NUM_BANKS-1:0]    words_i,
   input  logic [SEL_W-1:0]              sel_i,
   output logic [BYTE_W-1:0]             rd_o
);

   logic [BYTE_W-1:0] sel_byte;

   always_comb begin
      sel_byte = '0;
      for (int k = 0; k < NUM_BANKS; k++)
         if (sel_i == SEL_W'(k))
            sel_byte = flags_to_byte(words_i[k]);
   end

   generate
      if (READ_REG) begin : g_reg
         logic [BYTE_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= sel_byte;
         end
         assign rd_o = rd_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rd_o = sel_byte;
      end
   endgenerate

endmodule

// File: rtl/frame_err_bank.sv
module frame_err_bank
   import fe_stat_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 8,
   parameter int unsigned SEL_W     = 3,
   parameter bit          READ_REG  = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_clr,
   input  logic [SEL_W-1:0] cur_frame,
   input  logic             bof_ok,
   input  logic             tx_starve,
   input  logic             tx_done,
   input  logic             rx_push,
   input  logic             fifo_full,
   input  logic             ev_framing,
   input  logic             ev_size,
   input  logic             ev_abort,
   input  logic             ev_crc,
   input  logic [SEL_W-1:0] bank_sel,
   output logic [7:0]       rd_data
);

   localparam int unsigned SLOTS = 1 << SEL_W;

   initial begin
      if (NUM_BANKS < 2 || NUM_BANKS > SLOTS)
         $error("frame_err_bank: NUM_BANKS must be 2..2**SEL_W");
      if (BYTE_W != 8)
         $error("frame_err_bank: read byte must be 8 bits");
   end

   err_flags_t                 set_flags;
   err_flags_t [NUM_BANKS-1:0] words;

   fe_event_capture u_cap (
      .tx_starve  (tx_starve),
      .tx_done    (tx_done),
      .rx_push    (rx_push),
      .fifo_full  (fifo_full),
      .ev_framing (ev_framing),
      .ev_size    (ev_size),
      .ev_abort   (ev_abort),
      .ev_crc     (ev_crc),
      .set_o      (set_flags)
   );

   generate
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
         logic       hit;
         logic       clr;
         err_flags_t set_k;

         assign hit   = (cur_frame == SEL_W'(k));
         assign clr   = err_clr | (bof_ok & hit);
         assign set_k = hit ? set_flags : '0;

         fe_bank_word u_word (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (clr),
            .set_i  (set_k),
            .word_o (words[k])
         );

         // R5 R8
         other_bank_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cur_frame != SEL_W'(k) && !err_clr) |=> $stable(words[k]));
      end
   endgenerate

   // R7
   global_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> (words == '0));

   fe_read_mux #(
      .NUM_BANKS (NUM_BANKS),
      .SEL_W     (SEL_W),
      .READ_REG  (READ_REG)
   ) u_mux (
      .clk     (clk),
      .rst_n   (rst_n),
      .words_i (words),
      .sel_i   (bank_sel),
      .rd_o    (rd_data)
   );

endmodule

// File: tb/sim_frame_err_bank.sv
module sim_frame_err_bank;

   typedef struct {
      logic [7:0] exp;
      logic [2:0] bank;
      string      req;
   } rd_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       err_clr = 0, bof_ok = 0, tx_starve = 0, tx_done = 0;
   logic       rx_push = 0, fifo_full = 0;
   logic       ev_framing = 0, ev_size = 0, ev_abort = 0, ev_crc = 0;
   logic [2:0] cur_frame = 0, bank_sel = 0;
   logic [7:0] rd_data;

   logic [7:0] model [8];
   rd_item_t   q[$];
   int         checks = 0, fails = 0;
   bit         done = 0;

   always #5 clk = ~clk;

   frame_err_bank u0 (
      .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .cur_frame(cur_frame),
      .bof_ok(bof_ok), .tx_starve(tx_starve), .tx_done(tx_done),
      .rx_push(rx_push), .fifo_full(fifo_full), .ev_framing(ev_framing),
      .ev_size(ev_size), .ev_abort(ev_abort), .ev_crc(ev_crc),
      .bank_sel(bank_sel), .rd_data(rd_data)
   );

   // Driver: one stimulus cycle, then model update per the requirements
   // ev = {framing, size, abort, crc}
   task automatic stim(input logic [2:0] f, input logic starve, input logic dn,
                       input logic push, input logic full, input logic [3:0] ev,
                       input logic bof, input logic clr);
      logic [7:0] setv;
      @(negedge clk);
      cur_frame = f; tx_starve = starve; tx_done = dn; rx_push = push;
      fifo_full = full; {ev_framing, ev_size, ev_abort, ev_crc} = ev;
      bof_ok = bof; err_clr = clr;
      @(negedge clk);
      tx_starve = 0; tx_done = 0; rx_push = 0; fifo_full = 0;
      {ev_framing, ev_size, ev_abort, ev_crc} = 4'b0; bof_ok = 0; err_clr = 0;
      setv = {starve & ~dn, push & full, ev, 2'b00};
      if (clr) for (int k = 0; k < 8; k++) model[k] = 8'h00;
      else if (bof) model[f] = 8'h00;
      else model[f] = model[f] | setv;
   endtask

   task automatic rd(input logic [2:0] b, input string req);
      rd_item_t it;
      @(negedge clk);
      bank_sel = b;
      it.exp = model[b]; it.bank = b; it.req = req;
      q.push_back(it);
   endtask

   // Monitor: pops expected items and compares
   initial begin
      rd_item_t it;
      forever begin
         @(negedge clk);
         #2;
         if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (rd_data !== it.exp || rd_data[1:0] !== 2'b00) begin
               fails++;
               $display("FAIL %s bank %0d actual=%02h expected=%02h",
                        it.req, it.bank, rd_data, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog all requirements actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 8; k++) model[k] = 8'h00;
      // R1 while reset is held
      rd(3'd0, "R1");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 8; k++) rd(3'(k), "R1");

      // R3 underrun, and starve with done ignored
      stim(3'd2, 1, 0, 0, 0, 4'b0, 0, 0);
      rd(3'd2, "R3");
      stim(3'd3, 1, 1, 0, 0, 4'b0, 0, 0);
      rd(3'd3, "R3");

      // R4 overrun, and push without full ignored
      stim(3'd5, 0, 0, 1, 1, 4'b0, 0, 0);
      rd(3'd5, "R4");
      stim(3'd6, 0, 0, 1, 0, 4'b0, 0, 0);
      rd(3'd6, "R4");

      // R5 per-flag bits to current bank only; R6 sticky accumulation
      stim(3'd1, 0, 0, 0, 0, 4'b1001, 0, 0);
      rd(3'd1, "R5");
      rd(3'd0, "R5");
      stim(3'd1, 0, 0, 0, 0, 4'b0110, 0, 0);
      rd(3'd1, "R6");
      rd(3'd1, "R6");
      rd(3'd1, "R6");

      // R8 BOF clears only current bank
      stim(3'd1, 0, 0, 0, 0, 4'b0, 1, 0);
      rd(3'd1, "R8");
      rd(3'd2, "R8");
      rd(3'd5, "R8");

      // R9 clear beats simultaneous event
      stim(3'd7, 1, 0, 1, 1, 4'b1111, 1, 0);
      rd(3'd7, "R9");
      stim(3'd7, 0, 0, 0, 0, 4'b0001, 0, 0);
      rd(3'd7, "R9");

      // R2 distinct pattern per bank, read each
      for (int k = 0; k < 8; k++)
         stim(3'(k), k[0], 0, k[1], 1, 4'(k + 3), 0, 0);
      for (int k = 7; k >= 0; k--) rd(3'(k), "R2");

      // R7 global clear, with a simultaneous event
      stim(3'd4, 1, 0, 1, 1, 4'b1111, 0, 1);
      for (int k = 0; k < 8; k++) rd(3'(k), "R7");

      repeat (4) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule